// File: doc/BRIEF.md
# Flash Block Lock Guard with Identifier Readout

This block keeps the protection state for an eight-block flash array: one lock bit per block and a single master lock bit. A command decoder in front of it presents one request at a time: an erase, a byte program, or a lock change. The request carries a target block, whether the programming supply is at a usable level, and the level of the three-level reset/override pin (low, normal or high voltage). One clock later the guard answers with either a one-cycle permit pulse or a one-cycle violation pulse. The status register uses the violation pulse to set its lock-violation and operation-error bits. A permitted lock change updates the stored bits on the same edge.

The guard also answers identifier-mode reads without waiting for a clock. Given a block number and an offset within that block, it returns the manufacturer code, the device code, a block's lock state or the master lock state. Reserved offsets read as zero. Lock bits are cleared at power-on. After that they change only through permitted lock commands. A low level on the reset pin does not clear them.

Top module: `flash_lock_guard`

## Requirements
- R1: After the synchronous power-on reset `rst`, all block lock bits and the master bit read as 0, and `permit` and `viol` are low.
- R2: Erase (op code 1) and program (op code 2) at normal reset level (level code 1; code 3 also counts as normal) are permitted when the target block's lock bit is 0 and rejected when it is 1.
- R3: At high-voltage level (level code 2), erase, program, set-block-lock (op code 3) and clear-all (op code 5) are permitted whatever the lock bits hold.
- R4: Set-master-lock (op code 4) is permitted only at level code 2. At any other level it is rejected and the master bit keeps its value.
- R5: At normal level, set-block-lock and clear-all are permitted while the master bit is 0 and rejected while it is 1.
- R6: A permitted clear-all zeroes every block lock bit at once and leaves the master bit unchanged.
- R7: A request made while `vpp_ok` is low, or while the level is low (code 0), is always rejected and alters no lock bit.
- R8: Identifier read of block 0 returns the manufacturer code at offset 0 and the device code at offset 1.
- R9: Identifier offset 2 of any block returns that block's lock bit in data bit 0, with all other bits zero. Offset 3 of block 0 returns the master bit the same way. Every other block/offset pair reads 0.
- R10: Lock bits keep their values while the reset pin sits at the low level.
- R11: Each valid request with op codes 1 to 5 produces exactly one of `permit` and `viol`, high for one cycle, in the cycle after it is sampled. No request, op code 0, and op codes 6 and 7 produce neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 none, 1 erase, 2 program, 3 set block lock, 4 set master, 5 clear all) |
| req_blk | input | 3 | Target block |
| vpp_ok | input | 1 | Programming supply above its lockout level |
| rp_lvl | input | 2 | Reset pin level: 0 low, 1 normal, 2 high voltage, 3 normal |
| id_blk | input | 3 | Identifier read block |
| id_off | input | 4 | Identifier read offset within the block |
| id_data | output | 8 | Identifier read data (combinational) |
| permit | output | 1 | One-cycle pulse: request allowed |
| viol | output | 1 | One-cycle pulse: request refused |

## Verification
The bench walks the lock state through unlocked, block-locked, master-locked and cleared conditions. In each condition it tries erase, program and each lock command at all three reset levels, and with the supply both valid and missing. This separates the block-bit gate from the master-bit gate, and both from the override and supply gates. After every request it reads the whole identifier space, including a reserved offset. A wrong lock update then appears immediately and in the right block. Runs of idle cycles, reserved op codes and back-to-back rejections show that the pulses are single-cycle and appear only when a request is made.

// File: rtl/flk_pkg.sv
`timescale 1ns/1ps
package flk_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ERASE = 3'd1,
        OP_PROG  = 3'd2,
        OP_SETB  = 3'd3,
        OP_SETM  = 3'd4,
        OP_CLRB  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        LV_LOW  = 2'd0,
        LV_NORM = 2'd1,
        LV_HIGH = 2'd2,
        LV_ALT  = 2'd3
    } lvl_e;

    typedef struct packed {
        logic permit;
        logic reject;
        logic wr_blk;
        logic wr_mst;
        logic clr_all;
    } verdict_t;

    function automatic logic op_active(op_e op);
        return (op == OP_ERASE) || (op == OP_PROG) || (op == OP_SETB) ||
               (op == OP_SETM) || (op == OP_CLRB);
    endfunction
endpackage

// File: rtl/flk_rules.sv
`timescale 1ns/1ps
module flk_rules
    import flk_pkg::*;
(
    input  logic     valid,
    input  op_e      op,
    input  logic     vpp_ok,
    input  lvl_e     lvl,
    input  logic     tgt_locked,
    input  logic     mst,
    output verdict_t verdict
);
    logic act, hv, alive, ok;

    always_comb begin
        act   = valid && op_active(op);
        hv    = (lvl == LV_HIGH);
        alive = vpp_ok && (lvl != LV_LOW);
        unique case (op)
            OP_ERASE, OP_PROG: ok = !tgt_locked || hv;
            OP_SETB,  OP_CLRB: ok = !mst || hv;
            OP_SETM:           ok = hv;
            default:           ok = 1'b0;
        endcase
        verdict.permit  = act && alive && ok;
        verdict.reject  = act && !(alive && ok);
        verdict.wr_blk  = verdict.permit && (op == OP_SETB);
        verdict.wr_mst  = verdict.permit && (op == OP_SETM);
        verdict.clr_all = verdict.permit && (op == OP_CLRB);
    end
endmodule

// File: rtl/flk_store.sv
`timescale 1ns/1ps
module flk_store #(
    parameter int NBLK = 8,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_blk,
    input  logic             wr_mst,
    input  logic             clr_all,
    input  logic [BLK_W-1:0] blk_idx,
    output logic [NBLK-1:0]  blk_lock,
    output logic             mst
);
    for (genvar g = 0; g < NBLK; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                blk_lock[g] <= 1'b0;
            else if (clr_all)
                blk_lock[g] <= 1'b0;
            else if (wr_blk && (blk_idx == BLK_W'(g)))
                blk_lock[g] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mst <= 1'b0;
        else if (wr_mst)
            mst <= 1'b1;
    end

    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    // R6: clearing the block bits never touches the master bit
    assert_clr_keeps_master_R6: assert property (@(posedge clk) disable iff (rst || !armed)
        (clr_all && !wr_mst) |=> $stable(mst));
endmodule

// File: rtl/flk_id.sv
`timescale 1ns/1ps
module flk_id #(
    parameter int NBLK = 8,
    parameter int OFF_W = 4,
    parameter int DW = 8,
    parameter logic [DW-1:0] MFR_CODE = 8'hB0,
    parameter logic [DW-1:0] DEV_CODE = 8'h4C,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic [BLK_W-1:0] id_blk,
    input  logic [OFF_W-1:0] id_off,
    input  logic [NBLK-1:0]  blk_lock,
    input  logic             mst,
    output logic [DW-1:0]    id_data
);
    localparam logic [OFF_W-1:0] OFF_MFR = OFF_W'(0);
    localparam logic [OFF_W-1:0] OFF_DEV = OFF_W'(1);
    localparam logic [OFF_W-1:0] OFF_BLK = OFF_W'(2);
    localparam logic [OFF_W-1:0] OFF_MST = OFF_W'(3);

    logic first;

    always_comb begin
        first   = (id_blk == '0);
        id_data = '0;
        if (first && id_off == OFF_MFR)
            id_data = MFR_CODE;
        else if (first && id_off == OFF_DEV)
            id_data = DEV_CODE;
        else if (id_off == OFF_BLK)
            id_data[0] = blk_lock[id_blk];
        else if (first && id_off == OFF_MST)
            id_data[0] = mst;
    end
endmodule

// File: rtl/flash_lock_guard.sv
`timescale 1ns/1ps
module flash_lock_guard
    import flk_pkg::*;
#(
    parameter int NBLK = 8,
    parameter int OFF_W = 4,
    parameter int DW = 8,
    parameter logic [DW-1:0] MFR_CODE = 8'hB0,
    parameter logic [DW-1:0] DEV_CODE = 8'h4C,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [BLK_W-1:0] req_blk,
    input  logic             vpp_ok,
    input  logic [1:0]       rp_lvl,
    input  logic [BLK_W-1:0] id_blk,
    input  logic [OFF_W-1:0] id_off,
    output logic [DW-1:0]    id_data,
    output logic             permit,
    output logic             viol
);
    verdict_t        v;
    logic [NBLK-1:0] blk_lock;
    logic            mst;

    flk_rules u_rules (
        .valid      (req_valid),
        .op         (op_e'(req_op)),
        .vpp_ok     (vpp_ok),
        .lvl        (lvl_e'(rp_lvl)),
        .tgt_locked (blk_lock[req_blk]),
        .mst        (mst),
        .verdict    (v)
    );

    flk_store #(.NBLK(NBLK)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_blk   (v.wr_blk),
        .wr_mst   (v.wr_mst),
        .clr_all  (v.clr_all),
        .blk_idx  (req_blk),
        .blk_lock (blk_lock),
        .mst      (mst)
    );

    flk_id #(.NBLK(NBLK), .OFF_W(OFF_W), .DW(DW),
             .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
        .id_blk   (id_blk),
        .id_off   (id_off),
        .blk_lock (blk_lock),
        .mst      (mst),
        .id_data  (id_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            permit <= 1'b0;
            viol   <= 1'b0;
        end else begin
            permit <= v.permit;
            viol   <= v.reject;
        end
    end

    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (rst)
        !(permit && viol));
    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!permit && !viol));
    assert_dead_supply_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (!vpp_ok || rp_lvl == 2'd0)) |=> !permit);
    assert_master_needs_hv_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd4 && rp_lvl != 2'd2) |=> !permit);
    assert_clear_all_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd5 && rp_lvl == 2'd2 && vpp_ok) |=> (blk_lock == '0));
    // R10: with the reset pin low no lock bit moves
    assert_low_level_holds_R10: assert property (@(posedge clk) disable iff (rst || !armed)
        (rp_lvl == 2'd0) |=> ($stable(blk_lock) && $stable(mst)));
endmodule

// File: tb/flash_lock_guard_tb.sv
`timescale 1ns/1ps
module flash_lock_guard_tb;
    localparam logic [7:0] MFR = 8'hB0;
    localparam logic [7:0] DEV = 8'h4C;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [2:0] req_op;
    logic [2:0] req_blk;
    logic       vpp_ok;
    logic [1:0] rp_lvl;
    logic [2:0] id_blk;
    logic [3:0] id_off;
    logic [7:0] id_data;
    logic       permit, viol;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit [7:0] m_blk;
    bit       m_mst;

    always #2 clk = ~clk;

    flash_lock_guard u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_blk(req_blk), .vpp_ok(vpp_ok), .rp_lvl(rp_lvl),
        .id_blk(id_blk), .id_off(id_off), .id_data(id_data),
        .permit(permit), .viol(viol)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic sweep_id();
        for (int b = 0; b < 8; b++) begin
            for (int o = 0; o < 6; o++) begin
                logic [7:0] e;
                e = 8'h00;
                if (b == 0 && o == 0) e = MFR;
                else if (b == 0 && o == 1) e = DEV;
                else if (o == 2) e = {7'b0, m_blk[b]};
                else if (b == 0 && o == 3) e = {7'b0, m_mst};
                id_blk = 3'(b);
                id_off = (o == 5) ? 4'd9 : 4'(o);
                #0.05;
                check((o < 2) ? "R8" : "R9", int'(id_data), int'(e),
                      $sformatf("id blk=%0d off=%0d", b, id_off));
            end
        end
    endtask

    task automatic do_req(input int op, input int blk, input int lvl, input bit vpp,
                          input string tag);
        bit act, hv, alive, ok, ep, ev;
        act   = (op >= 1 && op <= 5);
        hv    = (lvl == 2);
        alive = vpp && (lvl != 0);
        case (op)
            1, 2:    ok = !m_blk[blk] || hv;
            3, 5:    ok = !m_mst || hv;
            4:       ok = hv;
            default: ok = 0;
        endcase
        ep = act && alive && ok;
        ev = act && !(alive && ok);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 3'(op);
        req_blk   = 3'(blk);
        rp_lvl    = 2'(lvl);
        vpp_ok    = vpp;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, int'(permit), int'(ep), $sformatf("permit op=%0d blk=%0d lvl=%0d vpp=%0d", op, blk, lvl, vpp));
        check(tag, int'(viol),   int'(ev), $sformatf("viol op=%0d blk=%0d lvl=%0d vpp=%0d", op, blk, lvl, vpp));
        if (ep && op == 3) m_blk[blk] = 1'b1;
        if (ep && op == 4) m_mst = 1'b1;
        if (ep && op == 5) m_blk = '0;
        sweep_id();
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check(tag, int'(permit | viol), 0, "pulse without request");
        end
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_op = 3'd0; req_blk = 3'd0;
        vpp_ok = 1'b1; rp_lvl = 2'd1; id_blk = 3'd0; id_off = 4'd0;
        m_blk = '0; m_mst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", int'(permit), 0, "permit after reset");
        check("R1", int'(viol), 0, "viol after reset");
        sweep_id();

        do_req(2, 3, 1, 1, "R2");
        do_req(3, 3, 1, 1, "R5");
        do_req(1, 3, 1, 1, "R2");
        do_req(2, 3, 3, 1, "R2");
        do_req(1, 4, 1, 1, "R2");
        do_req(1, 3, 2, 1, "R3");
        do_req(2, 3, 2, 1, "R3");
        do_req(4, 0, 1, 1, "R4");
        do_req(4, 0, 0, 1, "R4");
        do_req(4, 0, 2, 0, "R7");
        do_req(4, 0, 2, 1, "R4");
        do_req(3, 5, 1, 1, "R5");
        do_req(5, 0, 1, 1, "R5");
        do_req(3, 5, 2, 1, "R3");
        do_req(3, 0, 2, 1, "R3");
        do_req(3, 7, 2, 1, "R3");
        do_req(1, 2, 0, 1, "R7");
        do_req(3, 1, 0, 1, "R7");
        @(negedge clk); rp_lvl = 2'd0;
        idle(5, "R10");
        sweep_id();
        do_req(2, 1, 1, 0, "R7");
        do_req(3, 1, 2, 0, "R7");
        do_req(0, 1, 2, 1, "R11");
        do_req(6, 1, 2, 1, "R11");
        do_req(7, 2, 1, 1, "R11");
        do_req(1, 5, 1, 1, "R11");
        do_req(2, 5, 1, 1, "R11");
        idle(3, "R11");
        do_req(5, 0, 2, 1, "R6");
        do_req(2, 5, 1, 1, "R6");
        do_req(5, 0, 2, 1, "R6");
        do_req(3, 6, 1, 1, "R5");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule